// File: doc/BRIEF.md
# CAN Error and Interrupt Flag Block

This block keeps the error-status byte and the interrupt-flag byte of a CAN controller. It watches the 8-bit transmit and receive error counters and derives, every clock, the warning, error-passive and bus-off conditions. It also records receive overruns, which happen when a message lands in a receive buffer whose full flag is still set.

Event pulses from the rest of the controller set sticky bits in the interrupt-flag byte: receive buffer loaded, transmit buffer finished, wake-up and message error. The error flag in that byte is raised by the block itself whenever the error byte changes. An interrupt-enable byte gates the flags onto an active-low interrupt pin.

A host reads the three bytes through a small address port and changes them through a masked write port. A masked write touches only the bits whose mask bit is 1, so single flags can be cleared without disturbing the rest. The block carries no data stream, so every pin is a plain level or one-cycle pulse and there is no valid/ready handshake. A write takes effect at the clock edge where `wr_en` is high and is never stalled.

Top module: `can_err_irq_flags`

## Requirements
- R1: Error byte (address 0) bit 1 is 1 when the receive counter is 96 or more, and bit 2 is 1 when the transmit counter is 96 or more. Bit 0 is the OR of bits 1 and 2. All three follow the counters with one cycle of latency.
- R2: Error byte bit 3 is 1 when the receive counter is 128 or more, and bit 4 is 1 when the transmit counter is 128 or more. Both have one cycle of latency.
- R3: Error byte bit 5 (bus-off) is 1 exactly when the transmit counter equals 255, with one cycle of latency.
- R4: Error byte bit 6 (bit 7) is set when `rx_arrive[0]` (`rx_arrive[1]`) pulses while interrupt-flag bit 0 (bit 1) is already 1. The bit stays set until the host clears it with a masked write to address 0. Writes to error-byte bits 0 to 5 have no effect.
- R5: The interrupt-flag byte (address 1) uses this layout: bit 0 and bit 1 are receive buffers 0 and 1 loaded (`rx_arrive`), bits 2 to 4 are transmit buffers 0 to 2 done (`tx_done`), bit 5 is error, bit 6 is wake-up and bit 7 is message error. Each bit is set one cycle after its pulse and stays set until it is cleared.
- R6: Interrupt-flag bit 5 is set one cycle after any cycle in which the error byte differs from its value in the previous cycle. It is not set while the error byte stays constant.
- R7: `irq_n` is 0 exactly while the bitwise AND of the interrupt-flag byte and the enable byte (address 2) is non-zero.
- R8: A write with `wr_en` high, address `wr_addr` and mask `wr_mask` loads `wr_data` into the masked bits only, at the next clock edge. If a hardware set event and a write of 0 hit the same bit in the same cycle, the bit ends up 1.
- R9: After reset, the error byte, the interrupt-flag byte and the enable byte all read 0, and `irq_n` is 1.
- R10: `rd_data` combinationally shows the byte selected by `rd_addr`: 0 selects the error byte, 1 the interrupt-flag byte, 2 the enable byte, and 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_err_cnt | input | 8 | Transmit error counter |
| rx_err_cnt | input | 8 | Receive error counter |
| rx_arrive | input | 2 | One-cycle pulse per receive buffer: message loaded |
| tx_done | input | 3 | One-cycle pulse per transmit buffer: transmission done |
| wake_evt | input | 1 | Wake-up event pulse |
| msg_err_evt | input | 1 | Message error event pulse |
| rd_addr | input | 2 | Read byte select |
| rd_data | output | 8 | Selected byte |
| wr_en | input | 1 | Masked write strobe |
| wr_addr | input | 2 | Write byte select |
| wr_mask | input | 8 | Bits to change |
| wr_data | input | 8 | New values for masked bits |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The threshold bits, overrun bits and event flags are all due one clock edge after their stimulus. The error interrupt flag is due two edges after a counter or overrun change: one edge for the error byte to update, and one more for the change to be seen. The bench drives every input on the falling edge and samples on the next falling edge, or on the one after it for the error flag. Reads and `irq_n` are combinational from registers, so they are checked half a step after the address is set. Both counters are swept exhaustively on their own and then on a coarse grid together, with the expected byte computed arithmetically.

// File: rtl/can_flag_pkg.sv
package can_flag_pkg;
  localparam int BYTE_W = 8;
  localparam int N_RXB = 2;
  localparam int N_TXB = 3;
  localparam logic [1:0] A_ERR = 2'd0;
  localparam logic [1:0] A_FLG = 2'd1;
  localparam logic [1:0] A_ENA = 2'd2;
  localparam int FLG_ERR = 5;
  localparam int FLG_WAKE = 6;
  localparam int FLG_MERR = 7;
  localparam int ERR_OVR0 = 6;
endpackage

// File: rtl/cef_err_status.sv
module cef_err_status
  import can_flag_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   tx_cnt,
  input  logic [CNT_W-1:0]   rx_cnt,
  input  logic [N_RXB-1:0]   rx_arrive,
  input  logic [N_RXB-1:0]   rx_full,
  input  logic [N_RXB-1:0]   ovr_we,
  input  logic [N_RXB-1:0]   ovr_wd,
  output logic [BYTE_W-1:0]  err_q
);
  localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS_LIM);

  logic rx_warn, tx_warn, rx_pass, tx_pass, bus_off;

  always_comb begin
    rx_warn = rx_cnt >= WARN_V;
    tx_warn = tx_cnt >= WARN_V;
    rx_pass = rx_cnt >= PASS_V;
    tx_pass = tx_cnt >= PASS_V;
    bus_off = &tx_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q[5:0] <= '0;
    else err_q[5:0] <= {bus_off, tx_pass, rx_pass, tx_warn, rx_warn, rx_warn | tx_warn};
  end

  for (genvar i = 0; i < N_RXB; i++) begin : g_ovr
    logic ovr_set;
    assign ovr_set = rx_arrive[i] & rx_full[i];
    always_ff @(posedge clk) begin
      if (!rst_n) err_q[ERR_OVR0+i] <= 1'b0;
      else if (ovr_set) err_q[ERR_OVR0+i] <= 1'b1;
      else if (ovr_we[i]) err_q[ERR_OVR0+i] <= ovr_wd[i];
    end
  end

  AST_BUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == '1) |=> err_q[5]); // R3
  AST_RX_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt >= PASS_V) |=> (err_q[3] && err_q[1] && err_q[0])); // R2
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[ERR_OVR0] && !(ovr_we[0] && !ovr_wd[0])) |=> err_q[ERR_OVR0]); // R4
endmodule

// File: rtl/cef_irq_flags.sv
module cef_irq_flags
  import can_flag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RXB-1:0]   rx_arrive,
  input  logic [N_TXB-1:0]   tx_done,
  input  logic               wake_evt,
  input  logic               msg_err_evt,
  input  logic [BYTE_W-1:0]  err_in,
  input  logic               we,
  input  logic [BYTE_W-1:0]  wmask,
  input  logic [BYTE_W-1:0]  wdata,
  output logic [BYTE_W-1:0]  flg_q
);
  logic [BYTE_W-1:0] err_prev;
  logic [BYTE_W-1:0] set_vec;
  logic err_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) err_prev <= '0;
    else err_prev <= err_in;
  end

  assign err_chg = err_in != err_prev;
  assign set_vec = {msg_err_evt, wake_evt, err_chg, tx_done, rx_arrive};

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) flg_q[b] <= 1'b0;
      else if (set_vec[b]) flg_q[b] <= 1'b1;
      else if (we && wmask[b]) flg_q[b] <= wdata[b];
    end
  end

  AST_RX0_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_arrive[0] |=> flg_q[0]); // R5
  AST_ERR_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_in != err_prev) |=> flg_q[FLG_ERR]); // R6
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wmask[FLG_WAKE] && !wake_evt) |=> (flg_q[FLG_WAKE] == $past(flg_q[FLG_WAKE]))); // R8
endmodule

// File: rtl/cef_reg_port.sv
module cef_reg_port
  import can_flag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         rd_addr,
  input  logic [BYTE_W-1:0]  err_b,
  input  logic [BYTE_W-1:0]  flg_b,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [BYTE_W-1:0]  wr_mask,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic               we_err,
  output logic               we_flg,
  output logic [BYTE_W-1:0]  ena_q,
  output logic [BYTE_W-1:0]  rd_data
);
  logic we_ena;

  assign we_err = wr_en && (wr_addr == A_ERR);
  assign we_flg = wr_en && (wr_addr == A_FLG);
  assign we_ena = wr_en && (wr_addr == A_ENA);

  always_ff @(posedge clk) begin
    if (!rst_n) ena_q <= '0;
    else if (we_ena) ena_q <= (ena_q & ~wr_mask) | (wr_data & wr_mask);
  end

  always_comb begin
    unique case (rd_addr)
      A_ERR:   rd_data = err_b;
      A_FLG:   rd_data = flg_b;
      A_ENA:   rd_data = ena_q;
      default: rd_data = '0;
    endcase
  end

  AST_ENA_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (we_ena && !wr_mask[0]) |=> (ena_q[0] == $past(ena_q[0]))); // R8
endmodule

// File: rtl/can_err_irq_flags.sv
module can_err_irq_flags
  import can_flag_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  tx_err_cnt,
  input  logic [CNT_W-1:0]  rx_err_cnt,
  input  logic [1:0]        rx_arrive,
  input  logic [2:0]        tx_done,
  input  logic              wake_evt,
  input  logic              msg_err_evt,
  input  logic [1:0]        rd_addr,
  output logic [7:0]        rd_data,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_mask,
  input  logic [7:0]        wr_data,
  output logic              irq_n
);
  logic [BYTE_W-1:0] err_b, flg_b, ena_b;
  logic we_err, we_flg;
  logic [N_RXB-1:0] ovr_we;

  assign ovr_we = {N_RXB{we_err}} & wr_mask[ERR_OVR0 +: N_RXB];

  cef_reg_port u_port (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .err_b(err_b), .flg_b(flg_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(wr_data),
    .we_err(we_err), .we_flg(we_flg), .ena_q(ena_b), .rd_data(rd_data)
  );

  cef_err_status #(.CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)) u_err (
    .clk(clk), .rst_n(rst_n), .tx_cnt(tx_err_cnt), .rx_cnt(rx_err_cnt),
    .rx_arrive(rx_arrive), .rx_full(flg_b[N_RXB-1:0]), .ovr_we(ovr_we),
    .ovr_wd(wr_data[ERR_OVR0 +: N_RXB]), .err_q(err_b)
  );

  cef_irq_flags u_flg (
    .clk(clk), .rst_n(rst_n), .rx_arrive(rx_arrive), .tx_done(tx_done),
    .wake_evt(wake_evt), .msg_err_evt(msg_err_evt), .err_in(err_b),
    .we(we_flg), .wmask(wr_mask), .wdata(wr_data), .flg_q(flg_b)
  );

  assign irq_n = ~|(flg_b & ena_b);

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (flg_b != '0)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> irq_n); // R9
endmodule

// File: tb/can_err_irq_flags_test.sv
`timescale 1ns/100ps
module can_err_irq_flags_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] tx_err_cnt = 0, rx_err_cnt = 0;
  logic [1:0] rx_arrive = 0;
  logic [2:0] tx_done = 0;
  logic wake_evt = 0, msg_err_evt = 0;
  logic [1:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_mask = 0, wr_data = 0;
  logic irq_n;
  int total = 0, bad = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  can_err_irq_flags uut (
    .clk(clk), .rst_n(rst_n), .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
    .rx_arrive(rx_arrive), .tx_done(tx_done), .wake_evt(wake_evt),
    .msg_err_evt(msg_err_evt), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_data(wr_data),
    .irq_n(irq_n)
  );

  function automatic logic [7:0] exp_err(input int tx, input int rx);
    logic [7:0] e;
    e = 0;
    e[1] = rx >= 96;
    e[2] = tx >= 96;
    e[0] = e[1] | e[2];
    e[3] = rx >= 128;
    e[4] = tx >= 128;
    e[5] = tx == 255;
    return e;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] m, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_mask = m; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_mask = 0; wr_data = 0;
  endtask

  task automatic pulse(input logic [1:0] rxa, input logic [2:0] txd, input logic wk, input logic me);
    rx_arrive = rxa; tx_done = txd; wake_evt = wk; msg_err_evt = me;
    @(negedge clk);
    rx_arrive = 0; tx_done = 0; wake_evt = 0; msg_err_evt = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #900000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R9 reset state
    rd(2'd0, v); chk("R9 err", v, 8'h00);
    rd(2'd1, v); chk("R9 flg", v, 8'h00);
    rd(2'd2, v); chk("R9 ena", v, 8'h00);
    chk("R9 irq_n", {7'd0, irq_n}, 8'h01);
    rd(2'd3, v); chk("R10 addr3", v, 8'h00);

    // R1 R2 R3 sweeps
    for (int t = 0; t < 256; t++) begin
      tx_err_cnt = t[7:0]; rx_err_cnt = 0;
      @(negedge clk);
      rd(2'd0, v); chk("R1/R2/R3 tx sweep", v & 8'h3F, exp_err(t, 0));
    end
    for (int r = 0; r < 256; r++) begin
      tx_err_cnt = 0; rx_err_cnt = r[7:0];
      @(negedge clk);
      rd(2'd0, v); chk("R1/R2 rx sweep", v & 8'h3F, exp_err(0, r));
    end
    for (int t = 0; t < 256; t += 17) begin
      for (int r = 0; r < 256; r += 17) begin
        tx_err_cnt = t[7:0]; rx_err_cnt = r[7:0];
        @(negedge clk);
        rd(2'd0, v); chk("R1/R2/R3 grid", v & 8'h3F, exp_err(t, r));
      end
    end
    tx_err_cnt = 95; rx_err_cnt = 0;
    @(negedge clk);
    rd(2'd0, v); chk("R1 below limit", v & 8'h3F, 8'h00);

    // R6 error flag timing
    idle(3);
    wr(2'd1, 8'hFF, 8'h00);
    rd(2'd1, v); chk("R8 clear all", v, 8'h00);
    idle(3);
    rd(2'd1, v); chk("R6 no change", v, 8'h00);
    tx_err_cnt = 96;
    @(negedge clk);
    rd(2'd1, v); chk("R6 not early", v, 8'h00);
    rd(2'd0, v); chk("R1 err byte", v, 8'h05);
    @(negedge clk);
    rd(2'd1, v); chk("R6 error flag", v, 8'h20);
    tx_err_cnt = 0;
    idle(3);
    wr(2'd1, 8'hFF, 8'h00);

    // R5 layout
    pulse(2'b01, 3'b000, 0, 0); rd(2'd1, v); chk("R5 rx0", v, 8'h01); wr(2'd1, 8'hFF, 0);
    pulse(2'b10, 3'b000, 0, 0); rd(2'd1, v); chk("R5 rx1", v, 8'h02); wr(2'd1, 8'hFF, 0);
    for (int k = 0; k < 3; k++) begin
      pulse(2'b00, 3'(1 << k), 0, 0); rd(2'd1, v); chk("R5 tx", v, 8'(4 << k)); wr(2'd1, 8'hFF, 0);
    end
    pulse(2'b00, 3'b000, 1, 0); rd(2'd1, v); chk("R5 wake", v, 8'h40); wr(2'd1, 8'hFF, 0);
    pulse(2'b00, 3'b000, 0, 1); rd(2'd1, v); chk("R5 merr", v, 8'h80);
    idle(2);
    rd(2'd1, v); chk("R5 sticky", v, 8'h80);
    wr(2'd1, 8'hFF, 0);

    // R4 overflow
    pulse(2'b01, 3'b000, 0, 0);
    rd(2'd0, v); chk("R4 no ovr first", v, 8'h00);
    pulse(2'b01, 3'b000, 0, 0);
    rd(2'd0, v); chk("R4 ovr0 set", v, 8'h40);
    wr(2'd1, 8'h01, 8'h00);
    idle(3);
    rd(2'd0, v); chk("R4 ovr0 sticky", v, 8'h40);
    wr(2'd0, 8'h3F, 8'h3F);
    rd(2'd0, v); chk("R4 low bits ignore write", v, 8'h40);
    wr(2'd0, 8'h40, 8'h00);
    rd(2'd0, v); chk("R4 ovr0 cleared", v, 8'h00);

    // R8 set wins over clear
    idle(3);
    wr(2'd1, 8'hFF, 8'h00);
    pulse(2'b10, 3'b000, 0, 0);
    rx_arrive = 2'b10;
    wr(2'd1, 8'h02, 8'h00);
    rx_arrive = 0;
    rd(2'd1, v); chk("R8 set wins", v & 8'h02, 8'h02);
    rd(2'd0, v); chk("R4 ovr1 set", v, 8'h80);
    pulse(2'b01, 3'b000, 0, 0);
    wr(2'd1, 8'h01, 8'h00);
    rd(2'd1, v); chk("R8 mask keeps others", v & 8'h03, 8'h02);

    // R7 interrupt pin
    wr(2'd0, 8'hC0, 8'h00);
    idle(3);
    wr(2'd1, 8'hFF, 8'h00);
    pulse(2'b00, 3'b001, 0, 0);
    chk("R7 disabled", {7'd0, irq_n}, 8'h01);
    wr(2'd2, 8'h04, 8'hFF);
    rd(2'd2, v); chk("R8 ena mask", v, 8'h04);
    chk("R7 asserted", {7'd0, irq_n}, 8'h00);
    wr(2'd2, 8'h01, 8'h00);
    chk("R7 still asserted", {7'd0, irq_n}, 8'h00);
    wr(2'd1, 8'h04, 8'h00);
    chk("R7 released", {7'd0, irq_n}, 8'h01);
    rd(2'd3, v); chk("R10 addr3 late", v, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule